// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block is a single DMA pipe that works through a circular ring of 8-byte descriptors in system memory. Software sets the ring's base address and its size in bytes, enables the pipe, and then hands work over by writing a byte offset into the ring to an event register. That offset is the producer position. The pipe reads each descriptor from its current offset through a one-request-at-a-time memory read port. It passes the buffer address, byte count and end-of-block flag to a data mover, and waits for the mover's completion strobe. After that completion it steps to the next slot, and it wraps to zero at the end of the ring.

Each descriptor is one 64-bit word. Bits 31:0 hold the buffer address, bits 47:32 the byte count and bits 63:48 the flags. Flag bit 15 asks for an interrupt, bit 14 marks end of transfer and bit 13 marks end of block. Per-pipe status bits record these completions and also record when the ring runs dry and when an error occurs. An enable mask selects which status bits drive the interrupt line. Software can halt the pipe between descriptors. A pulsed reset register returns every register and the ring position to their defaults.

Top module: `desc_ring_pipe`

## Requirements
- R1: After the synchronous `rst`, every register reads zero, `irq` is low and neither `rd_req` nor `mv_start` is asserted.
- R2: The pipe fetches the descriptor at address base + current offset and holds `rd_req` and `rd_addr` until `rd_valid`. It then starts the mover with `mv_addr` = data[31:0], `mv_len` = data[47:32] and `mv_eob` = data[61], the end-of-block flag.
- R3: Descriptors are processed in ring order from the current offset up to, but not including, the producer offset. The offset advances by 8 after each mover completion and becomes 0 when it reaches the ring size. `mv_start` is a one-cycle pulse.
- R4: Register 9 reads the current descriptor offset in its low 16 bits.
- R5: On completion, flag bit 15 (data[63]) sets status bit 0 and flag bit 14 (data[62]) sets status bit 5.
- R6: A completion that leaves the current offset equal to the producer offset sets status bit 3 (out of descriptors). The pipe then idles until the producer offset moves.
- R7: A fetched descriptor with a byte count of zero sets status bit 4 and starts no mover transfer. The pipe then stays stopped until a pipe reset.
- R8: An event write (register 8) whose low three bits are not zero sets status bit 4 and stops the pipe.
- R9: While the halt register (register 2, bit 0) is 1, no new descriptor is started. Writing 0 resumes from the same offset.
- R10: Writing ones to register 4 clears the matching status bits of register 3. `irq` is the OR of status (register 3) ANDed with the enable register (register 5).
- R11: Writing 1 and then 0 to register 1 returns all registers and the ring offset to zero.
- R12: Control register 0 has the enable in bit 1, the direction in bit 3 (driven on `mv_dir`) and system mode in bit 5. With bit 1 clear, no descriptor is fetched.
- R13: The ring base register (register 6) always reads with its low three bits zero. The ring size is register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rd_req | output | 1 | Descriptor read request, held until `rd_valid` |
| rd_addr | output | 32 | Descriptor byte address |
| rd_valid | input | 1 | Descriptor read data valid |
| rd_data | input | 64 | Descriptor word |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_addr | output | 32 | Buffer address for the mover |
| mv_len | output | 16 | Buffer byte count for the mover |
| mv_eob | output | 1 | End-of-block flag of the descriptor |
| mv_dir | output | 1 | Transfer direction from control bit 3 |
| mv_done | input | 1 | Mover completion strobe |
| irq | output | 1 | Pipe interrupt request |

## Verification
The first pattern is a short burst of three descriptors that ends exactly at the producer offset. It shows whether the flag-driven status bits and the dry condition are raised by the right descriptor. A batch issued under halt and a later batch that crosses the end of the ring separate correct stop/resume and wrap from an off-by-one ring boundary. Running with the enable bit clear and with a different direction shows control gating. The two error sources, a misaligned producer write and a zero-length descriptor, are each followed by idle cycles and a pulsed pipe reset. These show that the pipe really stops and that the reset restores every register.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int OFS_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int ST_W       = 6;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_PRST  = 4'd1;
    localparam logic [3:0] RA_HALT  = 4'd2;
    localparam logic [3:0] RA_STAT  = 4'd3;
    localparam logic [3:0] RA_CLR   = 4'd4;
    localparam logic [3:0] RA_IEN   = 4'd5;
    localparam logic [3:0] RA_BASE  = 4'd6;
    localparam logic [3:0] RA_SIZE  = 4'd7;
    localparam logic [3:0] RA_EVENT = 4'd8;
    localparam logic [3:0] RA_SWOFS = 4'd9;

    localparam int ST_DONE = 0;
    localparam int ST_DRY  = 3;
    localparam int ST_ERR  = 4;
    localparam int ST_EOT  = 5;

    localparam int CTRL_EN  = 1;
    localparam int CTRL_DIR = 3;
    localparam logic [31:0] CTRL_MASK = 32'h0000_002A;

    localparam int FL_INT = 15;
    localparam int FL_EOT = 14;
    localparam int FL_EOB = 13;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] count;
        logic [31:0] addr;
    } desc_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_FETCH,
        E_ISSUE,
        E_WAIT
    } eng_state_e;

    typedef struct packed {
        logic done_int;
        logic done_eot;
        logic dry;
        logic bad_len;
    } eng_evt_t;

    function automatic logic [OFS_W-1:0] ring_next(input logic [OFS_W-1:0] cur,
                                                   input logic [OFS_W-1:0] size);
        logic [OFS_W:0] nx;
        nx = {1'b0, cur} + (OFS_W+1)'(DESC_BYTES);
        return (nx >= {1'b0, size}) ? '0 : nx[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  eng_evt_t         evt,
    input  logic [OFS_W-1:0] cur_ofs,
    output logic             soft_rst,
    output logic             pipe_en,
    output logic             pipe_dir,
    output logic [AW-1:0]    base_q,
    output logic [OFS_W-1:0] size_q,
    output logic [OFS_W-1:0] prod_q,
    output logic             halt_q,
    output logic             stopped_q,
    output logic             irq
);

    logic            prst_q;
    logic [31:0]     ctrl_q;
    logic [ST_W-1:0] stat_q, ien_q, set_v, clr_v;
    logic            bad_evt;

    function automatic logic hit(input logic [3:0] a);
        return reg_wr && (reg_addr == a);
    endfunction

    assign soft_rst = prst_q | (hit(RA_PRST) & reg_wdata[0]);
    assign bad_evt  = hit(RA_EVENT) && (reg_wdata[2:0] != 3'b000);
    assign clr_v    = hit(RA_CLR) ? reg_wdata[ST_W-1:0] : '0;

    always_comb begin
        set_v          = '0;
        set_v[ST_DONE] = evt.done_int;
        set_v[ST_EOT]  = evt.done_eot;
        set_v[ST_DRY]  = evt.dry;
        set_v[ST_ERR]  = evt.bad_len | bad_evt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prst_q <= 1'b0;
        else if (hit(RA_PRST))
            prst_q <= reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q    <= '0;
            halt_q    <= 1'b0;
            stat_q    <= '0;
            ien_q     <= '0;
            base_q    <= '0;
            size_q    <= '0;
            prod_q    <= '0;
            stopped_q <= 1'b0;
        end else begin
            if (hit(RA_CTRL))  ctrl_q <= reg_wdata & CTRL_MASK;
            if (hit(RA_HALT))  halt_q <= reg_wdata[0];
            if (hit(RA_IEN))   ien_q  <= reg_wdata[ST_W-1:0];
            if (hit(RA_BASE))  base_q <= {reg_wdata[AW-1:3], 3'b000};
            if (hit(RA_SIZE))  size_q <= reg_wdata[OFS_W-1:0];
            if (hit(RA_EVENT)) prod_q <= reg_wdata[OFS_W-1:0];
            stat_q    <= (stat_q & ~clr_v) | set_v;
            stopped_q <= stopped_q | set_v[ST_ERR];
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = ctrl_q;
            RA_PRST:  reg_rdata = {31'b0, prst_q};
            RA_HALT:  reg_rdata = {31'b0, halt_q};
            RA_STAT:  reg_rdata = 32'(stat_q);
            RA_IEN:   reg_rdata = 32'(ien_q);
            RA_BASE:  reg_rdata = 32'(base_q);
            RA_SIZE:  reg_rdata = 32'(size_q);
            RA_EVENT: reg_rdata = 32'(prod_q);
            RA_SWOFS: reg_rdata = 32'(cur_ofs);
            default:  reg_rdata = '0;
        endcase
    end

    assign pipe_en  = ctrl_q[CTRL_EN];
    assign pipe_dir = ctrl_q[CTRL_DIR];
    assign irq      = |(stat_q & ien_q);

endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             pipe_en,
    input  logic             pipe_dir,
    input  logic [AW-1:0]    base_q,
    input  logic [OFS_W-1:0] size_q,
    input  logic [OFS_W-1:0] prod_q,
    input  logic             halt_q,
    input  logic             stopped_q,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_valid,
    input  logic [63:0]      rd_data,
    output logic             mv_start,
    output logic [31:0]      mv_addr,
    output logic [15:0]      mv_len,
    output logic             mv_eob,
    output logic             mv_dir,
    input  logic             mv_done,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             eng_idle,
    output eng_evt_t         evt
);

    eng_state_e       state_q;
    desc_t            desc_q, fetched;
    logic [OFS_W-1:0] cur_q, nxt_ofs;
    logic             unused_flag_bits;

    assign fetched          = desc_t'(rd_data);
    assign unused_flag_bits = ^fetched.flags[12:0];
    assign nxt_ofs          = ring_next(cur_q, size_q);

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= E_IDLE;
            cur_q   <= '0;
            desc_q  <= '0;
        end else begin
            case (state_q)
                E_IDLE:
                    if (pipe_en && !halt_q && !stopped_q && (cur_q != prod_q))
                        state_q <= E_FETCH;
                E_FETCH:
                    if (rd_valid) begin
                        desc_q  <= fetched;
                        state_q <= (fetched.count == '0) ? E_IDLE : E_ISSUE;
                    end
                E_ISSUE:
                    state_q <= E_WAIT;
                E_WAIT:
                    if (mv_done) begin
                        cur_q   <= nxt_ofs;
                        state_q <= E_IDLE;
                    end
                default:
                    state_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        evt          = '0;
        evt.bad_len  = (state_q == E_FETCH) && rd_valid && (fetched.count == '0);
        if ((state_q == E_WAIT) && mv_done) begin
            evt.done_int = desc_q.flags[FL_INT];
            evt.done_eot = desc_q.flags[FL_EOT];
            evt.dry      = (nxt_ofs == prod_q);
        end
    end

    assign rd_req   = (state_q == E_FETCH);
    assign rd_addr  = base_q + AW'(cur_q);
    assign mv_start = (state_q == E_ISSUE);
    assign mv_addr  = desc_q.addr;
    assign mv_len   = desc_q.count;
    assign mv_eob   = desc_q.flags[FL_EOB];
    assign mv_dir   = pipe_dir;
    assign cur_ofs  = cur_q;
    assign eng_idle = (state_q == E_IDLE);

endmodule

// File: rtl/desc_ring_pipe.sv
module desc_ring_pipe
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [63:0]   rd_data,
    output logic          mv_start,
    output logic [31:0]   mv_addr,
    output logic [15:0]   mv_len,
    output logic          mv_eob,
    output logic          mv_dir,
    input  logic          mv_done,
    output logic          irq
);

    eng_evt_t         evt;
    logic [OFS_W-1:0] cur_ofs, size_q, prod_q;
    logic [AW-1:0]    base_q;
    logic             soft_rst, pipe_en, pipe_dir, halt_q, stopped, eng_idle;

    dring_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .cur_ofs   (cur_ofs),
        .soft_rst  (soft_rst),
        .pipe_en   (pipe_en),
        .pipe_dir  (pipe_dir),
        .base_q    (base_q),
        .size_q    (size_q),
        .prod_q    (prod_q),
        .halt_q    (halt_q),
        .stopped_q (stopped),
        .irq       (irq)
    );

    dring_engine #(.AW(AW)) u_eng (
        .clk       (clk),
        .srst      (rst | soft_rst),
        .pipe_en   (pipe_en),
        .pipe_dir  (pipe_dir),
        .base_q    (base_q),
        .size_q    (size_q),
        .prod_q    (prod_q),
        .halt_q    (halt_q),
        .stopped_q (stopped),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mv_start  (mv_start),
        .mv_addr   (mv_addr),
        .mv_len    (mv_len),
        .mv_eob    (mv_eob),
        .mv_dir    (mv_dir),
        .mv_done   (mv_done),
        .cur_ofs   (cur_ofs),
        .eng_idle  (eng_idle),
        .evt       (evt)
    );

endmodule

// File: rtl/dring_checker.sv
module dring_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          soft_rst,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          mv_start,
    input logic [15:0]   mv_len,
    input logic          stopped,
    input logic          eng_idle,
    input logic [15:0]   cur_ofs
);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    p_ofs_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        cur_ofs[2:0] == 3'b000);

    p_no_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
        mv_start |-> (mv_len != 16'd0));

    p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (stopped && eng_idle) |=> !rd_req);

    p_soft_reset_r11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!rd_req && !mv_start && cur_ofs == 16'd0));

endmodule

bind desc_ring_pipe dring_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .mv_start (mv_start),
    .mv_len   (mv_len),
    .stopped  (stopped),
    .eng_idle (eng_idle),
    .cur_ofs  (cur_ofs)
);

// File: tb/desc_ring_pipe_test.sv
module desc_ring_pipe_test;

    localparam int A_CTRL = 0, A_PRST = 1, A_HALT = 2, A_STAT = 3, A_CLR = 4;
    localparam int A_IEN = 5, A_BASE = 6, A_SIZE = 7, A_EVENT = 8, A_SWOFS = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd9;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr;
    logic [63:0] rd_data = '0;
    logic        mv_start, mv_eob, mv_dir, mv_done = 1'b0, irq;
    logic [31:0] mv_addr;
    logic [15:0] mv_len;

    always #5 clk = ~clk;

    desc_ring_pipe uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_len(mv_len),
        .mv_eob(mv_eob), .mv_dir(mv_dir), .mv_done(mv_done), .irq(irq)
    );

    int vectors = 0, miscompares = 0, moves = 0;

    logic [63:0] ring [16];
    int m_cur, m_prod, m_stat, m_ien, m_base, m_size, m_ctrl, m_stop;
    bit p_wr, p_done, p_zero;
    int p_waddr;
    logic [31:0] p_wdata;
    logic [15:0] p_flags, held_flags;
    int rd_cnt = -1, mv_cnt = -1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int c);
        int n = c + 8;
        return (n >= m_size) ? 0 : n;
    endfunction

    task automatic model_clear();
        m_cur = 0; m_prod = 0; m_stat = 0; m_ien = 0;
        m_base = 0; m_size = 0; m_ctrl = 0; m_stop = 0;
    endtask

    task automatic apply_write(input int a, input logic [31:0] d);
        case (a)
            A_CTRL:  m_ctrl = d & 32'h2A;
            A_PRST:  if (d[0]) model_clear();
            A_CLR:   m_stat = m_stat & ~int'(d[5:0]);
            A_IEN:   m_ien = int'(d[5:0]);
            A_BASE:  m_base = int'(d & 32'hFFFF_FFF8);
            A_SIZE:  m_size = int'(d[15:0]);
            A_EVENT: begin
                m_prod = int'(d[15:0]);
                if (d[2:0] != 3'b000) begin m_stat |= 16; m_stop = 1; end
            end
            default: ;
        endcase
    endtask

    task automatic tick();
        int setb;
        int last_addr;
        @(negedge clk);
        setb = 0;
        if (rst) model_clear();
        if (p_done) begin
            if (p_flags[15]) setb |= 1;
            if (p_flags[14]) setb |= 32;
            m_cur = nxt(m_cur);
            if (m_cur == m_prod) setb |= 8;
        end
        if (p_zero) begin setb |= 16; m_stop = 1; end
        if (p_wr) apply_write(p_waddr, p_wdata);
        m_stat |= setb;
        p_wr = 0; p_done = 0; p_zero = 0;
        last_addr = int'(reg_addr);
        // R10: interrupt line follows masked status every cycle
        if (!rst) check("R10 irq", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
        // R4: offset register tracks the ring position every cycle
        if (!rst && last_addr == A_SWOFS && !reg_wr)
            check("R4 swofs", reg_rdata, m_cur);
        reg_wr = 0; reg_addr = 4'd9; rd_valid = 0; mv_done = 0;
        if (mv_start) begin
            // R2 R12: mover receives the fields of the descriptor at the current slot
            check("R2 mv_addr", mv_addr, ring[m_cur/8][31:0]);
            check("R2 mv_len", {16'b0, mv_len}, {16'b0, ring[m_cur/8][47:32]});
            check("R2 mv_eob", {31'b0, mv_eob}, {31'b0, ring[m_cur/8][61]});
            check("R12 mv_dir", {31'b0, mv_dir}, {31'b0, m_ctrl[3]});
            held_flags = ring[m_cur/8][63:48];
            moves++;
            mv_cnt = 2;
        end
        if (rd_req && rd_cnt < 0) begin
            check("R2 rd_addr", rd_addr, m_base + m_cur);
            rd_cnt = 2;
        end
        if (rd_cnt >= 0) begin
            if (rd_cnt == 0) begin
                rd_valid = 1;
                rd_data = ring[(rd_addr - m_base) / 8];
                if (rd_data[47:32] == 16'd0) p_zero = 1;
                rd_cnt = -1;
            end else rd_cnt--;
        end
        if (mv_cnt >= 0) begin
            if (mv_cnt == 0) begin
                mv_done = 1; p_done = 1; p_flags = held_flags; mv_cnt = -1;
            end else mv_cnt--;
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
        p_wr = 1; p_waddr = a; p_wdata = d;
        tick();
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        reg_addr = 4'(a);
        #1;
        check(req, reg_rdata, exp);
        tick();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setup(input logic [31:0] ctrl);
        wr(A_BASE, 32'h0000_1003);
        wr(A_SIZE, 128);
        wr(A_IEN, 32'h3F);
        wr(A_CTRL, ctrl);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_clear();
        for (int i = 0; i < 16; i++) begin
            ring[i][31:0]  = 32'h8000_0000 + i * 32'h100;
            ring[i][47:32] = 16'(16 + i);
            ring[i][63:48] = (i % 3 == 0) ? 16'h8000 : (i % 3 == 1) ? 16'h4000 : 16'h2000;
        end
        run(3);
        rst = 0;
        tick();
        // R1: reset state
        rd(A_STAT, 0, "R1 stat");
        rd(A_CTRL, 0, "R1 ctrl");
        rd(A_SWOFS, 0, "R1 swofs");
        check("R1 rd_req", {31'b0, rd_req}, 0);
        check("R1 mv_start", {31'b0, mv_start}, 0);
        check("R1 irq", {31'b0, irq}, 0);

        setup(32'h2A);
        rd(A_BASE, 32'h0000_1000, "R13 base aligned");
        rd(A_CTRL, 32'h2A, "R12 ctrl");

        // R3 R5 R6: three descriptors ending at the producer
        wr(A_EVENT, 24);
        run(60);
        check("R3 moves", moves, 3);
        rd(A_STAT, 32'h29, "R5 R6 stat");
        check("R10 irq high", {31'b0, irq}, 1);

        // R10: write-one clear
        wr(A_CLR, 32'h3F);
        rd(A_STAT, 0, "R10 cleared");
        check("R10 irq low", {31'b0, irq}, 0);

        // R9: halt holds work back, release resumes
        wr(A_HALT, 1);
        wr(A_EVENT, 64);
        run(40);
        check("R9 halted moves", moves, 3);
        rd(A_SWOFS, 24, "R9 halted ofs");
        wr(A_HALT, 0);
        run(100);
        check("R9 resumed moves", moves, 8);

        // R3: wrap past the end of the ring
        wr(A_EVENT, 16);
        run(200);
        check("R3 wrap moves", moves, 18);
        rd(A_SWOFS, 16, "R3 wrap ofs");

        // R12: enable gating and direction
        wr(A_CLR, 32'h3F);
        wr(A_CTRL, 0);
        wr(A_EVENT, 40);
        run(40);
        check("R12 disabled moves", moves, 18);
        wr(A_CTRL, 32'h22);
        run(100);
        check("R12 enabled moves", moves, 21);

        // R8: misaligned producer stops the pipe
        wr(A_CLR, 32'h3F);
        wr(A_EVENT, 44);
        rd(A_STAT, 32'h10, "R8 err");
        run(40);
        check("R8 stopped moves", moves, 21);

        // R11: pulsed pipe reset
        wr(A_PRST, 1);
        wr(A_PRST, 0);
        rd(A_BASE, 0, "R11 base");
        rd(A_STAT, 0, "R11 stat");
        rd(A_EVENT, 0, "R11 event");
        rd(A_SWOFS, 0, "R11 swofs");
        rd(A_SIZE, 0, "R11 size");

        // R7: zero-length descriptor
        ring[2][47:32] = 16'd0;
        setup(32'h2A);
        wr(A_EVENT, 32);
        run(80);
        check("R7 moves", moves, 23);
        rd(A_STAT, 32'h31, "R7 stat");
        rd(A_SWOFS, 16, "R7 ofs");
        run(30);
        check("R7 still stopped", moves, 23);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule